// File: doc/BRIEF.md
# USB debug port mode controller

This block sits beside a host controller's debug port logic and decides, every clock cycle, how the debug port should behave. It reads the debug ownership and debug enable bits held in the debug registers, along with the port-enable, run/stop and suspend bits of the root port, and settles on one of six behaviours. The behaviours are: port not used for debug, keepalive mode, SOF-carried mode, shared mode, suspended, and an invalid combination that software should never set up.

In keepalive mode the block asks an external packet transmitter for a standalone 32-bit SYNC keepalive at a fixed interval (1 ms by default, under the 2 ms the attached debug device tolerates). In every mode that carries debug traffic it polls for a pending software debug request at a fixed interval (125 us by default). A poll that finds a pending request yields a one-cycle grant. After a port reset, or a suspend/resume sequence, a sticky hold-off flag blocks every grant until the transmitter reports that an SOF has been sent. The timer intervals are derived from a clock-frequency parameter, and both timers restart whenever the selected behaviour changes.

Top module: `usb_dbg_mode_ctrl`

## Requirements
- R1: While owner_i is 0 or dbg_en_i is 0, mode_o is 0 (not used) and ka_req_o, poll_o, dbg_grant_o and invalid_o all stay 0.
- R2: With owner_i and dbg_en_i both 1, mode_o takes the following values one clock edge after the inputs settle. port_en_i=0 with run_i=0 gives 1 (keepalive). port_en_i=0 with run_i=1 gives 2 (SOF-carried). port_en_i=1, susp_i=0, run_i=1 gives 3 (shared). port_en_i=1 with susp_i=1 gives 4 (suspended). port_en_i=1, susp_i=0, run_i=0 gives 5 (invalid), and in that case invalid_o is 1. In every other mode invalid_o is 0.
- R3: In mode 1, ka_req_o is a one-cycle strobe. The first strobe comes KA_CYC cycles after entry, counting the edge that latches the new mode as cycle 1, and later strobes follow every KA_CYC cycles. KA_CYC is CLK_KHZ*KA_US/1000. ka_req_o never rises in any other mode.
- R4: In modes 1, 2 and 3, poll_o is a one-cycle strobe. The first strobe comes POLL_CYC cycles after entry and later strobes follow every POLL_CYC cycles, where POLL_CYC is CLK_KHZ*POLL_US/1000.
- R5: dbg_grant_o is 1 exactly in the cycles where poll_o is 1, dbg_req_i is 1 and holdoff_o is 0.
- R6: In modes 0, 4 and 5, neither poll_o nor dbg_grant_o is ever 1.
- R7: A change between two debug-carrying modes restarts both timers. The next poll_o comes POLL_CYC cycles after the change, whatever the timer phase was before it.
- R8: holdoff_o becomes 1 on the cycle after an edge that sees owner_i and dbg_en_i at 1 together with port_reset_i=1, or together with port_en_i=1 and susp_i=1. It stays 1 while either condition lasts, even if sof_sent_i pulses.
- R9: holdoff_o returns to 0 only on the cycle after an edge that sees sof_sent_i=1 with neither set condition of R8 present. While holdoff_o is 1, polls still occur but no grant is issued.
- R10: When a keepalive strobe and a poll fall due in the same cycle, ka_req_o and poll_o are both 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| owner_i | input | 1 | Debug register: port owned by the debug function |
| dbg_en_i | input | 1 | Debug register: debug port enabled |
| port_en_i | input | 1 | Port control: port enabled |
| run_i | input | 1 | Host controller running (1) or stopped (0) |
| susp_i | input | 1 | Port control: port suspended |
| port_reset_i | input | 1 | Port reset in progress |
| sof_sent_i | input | 1 | One-cycle pulse: an SOF packet went out |
| dbg_req_i | input | 1 | Software debug request pending |
| mode_o | output | 3 | Selected behaviour (encoding in R2) |
| invalid_o | output | 1 | Invalid control combination |
| ka_req_o | output | 1 | One-cycle SYNC keepalive request |
| poll_o | output | 1 | One-cycle request-poll strobe |
| dbg_grant_o | output | 1 | One-cycle debug transaction grant |
| holdoff_o | output | 1 | Debug transactions held off |

## Verification
A keepalive request and a poll for software requests can fall in the same cycle, because both timers restart together on mode entry and the keepalive interval is a multiple of the poll interval. The bench enters keepalive mode from the unused state with a request pending and follows two keepalive periods cycle by cycle. It requires ka_req_o only on multiples of the keepalive interval and poll_o with dbg_grant_o on every multiple of the poll interval, so on the shared cycles both strobes must appear. A second case pits a pending hold-off against a poll: the poll must still show while the grant stays low until an SOF pulse clears the flag.

// File: rtl/dbgm_pkg.sv
`timescale 1ns/1ps
package dbgm_pkg;

  typedef enum logic [2:0] {
    MODE_UNUSED = 3'd0,
    MODE_KALIVE = 3'd1,
    MODE_SOFKA  = 3'd2,
    MODE_SHARED = 3'd3,
    MODE_SUSP   = 3'd4,
    MODE_BAD    = 3'd5
  } mode_e;

  // Cycles in an interval of 'us' microseconds at 'khz' kHz.
  function automatic int us_to_cyc(input int khz, input int us);
    return (khz * us) / 1000;
  endfunction

  // Behaviour selected from the five control bits.
  function automatic mode_e decode_mode(input logic own, input logic en,
                                        input logic pe, input logic run,
                                        input logic susp);
    if (!own || !en) return MODE_UNUSED;
    if (!pe)         return run ? MODE_SOFKA : MODE_KALIVE;
    if (susp)        return MODE_SUSP;
    if (run)         return MODE_SHARED;
    return MODE_BAD;
  endfunction

  // Modes in which debug requests are polled.
  function automatic logic carries_debug(input mode_e m);
    return (m == MODE_KALIVE) || (m == MODE_SOFKA) || (m == MODE_SHARED);
  endfunction

  // Sticky hold-off next state: set wins over clear.
  function automatic logic hold_next(input logic set, input logic clr,
                                     input logic cur);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/dbgm_timer.sv
`timescale 1ns/1ps
module dbgm_timer #(
  parameter int LIM = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (LIM < 2) ? 1 : $clog2(LIM);
  localparam logic [CW-1:0] LAST = CW'(LIM - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last_w;

  assign at_last_w = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i || !run_i) begin
      cnt_q <= '0;
    end else if (at_last_w) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && at_last_w;
endmodule

// File: rtl/dbgm_holdoff.sv
`timescale 1ns/1ps
module dbgm_holdoff
  import dbgm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic hold_o
);
  logic hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_next(set_i, clr_i, hold_q);
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/usb_dbg_mode_ctrl.sv
`timescale 1ns/1ps
module usb_dbg_mode_ctrl
  import dbgm_pkg::*;
#(
  parameter int CLK_KHZ = 100000,
  parameter int KA_US   = 1000,
  parameter int POLL_US = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       owner_i,
  input  logic       dbg_en_i,
  input  logic       port_en_i,
  input  logic       run_i,
  input  logic       susp_i,
  input  logic       port_reset_i,
  input  logic       sof_sent_i,
  input  logic       dbg_req_i,
  output logic [2:0] mode_o,
  output logic       invalid_o,
  output logic       ka_req_o,
  output logic       poll_o,
  output logic       dbg_grant_o,
  output logic       holdoff_o
);
  localparam int KA_CYC   = us_to_cyc(CLK_KHZ, KA_US);
  localparam int POLL_CYC = us_to_cyc(CLK_KHZ, POLL_US);

  mode_e mode_c, mode_q;
  logic  mode_chg_w;
  logic  active_w;
  logic  ka_run_w;
  logic  ka_tick_w;
  logic  poll_tick_w;
  logic  dbg_on_w;
  logic  hold_set_w;
  logic  hold_w;

  assign mode_c = decode_mode(owner_i, dbg_en_i, port_en_i, run_i, susp_i);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_UNUSED;
    else        mode_q <= mode_c;
  end

  assign mode_chg_w = (mode_c != mode_q);
  assign active_w   = carries_debug(mode_q);
  assign ka_run_w   = (mode_q == MODE_KALIVE);

  dbgm_timer #(.LIM(KA_CYC)) ka_tmr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (ka_run_w),
    .restart_i (mode_chg_w),
    .tick_o    (ka_tick_w)
  );

  dbgm_timer #(.LIM(POLL_CYC)) poll_tmr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (active_w),
    .restart_i (mode_chg_w),
    .tick_o    (poll_tick_w)
  );

  assign dbg_on_w   = owner_i && dbg_en_i;
  assign hold_set_w = dbg_on_w && (port_reset_i || (port_en_i && susp_i));

  dbgm_holdoff hold_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (hold_set_w),
    .clr_i  (sof_sent_i),
    .hold_o (hold_w)
  );

  assign mode_o      = mode_q;
  assign invalid_o   = (mode_q == MODE_BAD);
  assign ka_req_o    = ka_tick_w;
  assign poll_o      = poll_tick_w;
  assign dbg_grant_o = poll_tick_w && dbg_req_i && !hold_w;
  assign holdoff_o   = hold_w;
endmodule

// File: rtl/dbgm_checker.sv
`timescale 1ns/1ps
module dbgm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       owner_i,
  input logic       dbg_en_i,
  input logic       port_reset_i,
  input logic       sof_sent_i,
  input logic       dbg_req_i,
  input logic [2:0] mode_o,
  input logic       ka_req_o,
  input logic       poll_o,
  input logic       dbg_grant_o,
  input logic       holdoff_o
);
  AST_KA_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ka_req_o |-> (mode_o == 3'd1)); // R3

  AST_KA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ka_req_o |=> !ka_req_o); // R3

  AST_GRANT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_grant_o |-> (poll_o && dbg_req_i && !holdoff_o)); // R5

  AST_QUIET_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd0 || mode_o == 3'd4 || mode_o == 3'd5) |-> (!poll_o && !dbg_grant_o)); // R6

  AST_HOLD_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_i && dbg_en_i && port_reset_i) |=> holdoff_o); // R8

  AST_HOLD_CLEAR_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holdoff_o) |-> $past(sof_sent_i)); // R9
endmodule

bind usb_dbg_mode_ctrl dbgm_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .owner_i      (owner_i),
  .dbg_en_i     (dbg_en_i),
  .port_reset_i (port_reset_i),
  .sof_sent_i   (sof_sent_i),
  .dbg_req_i    (dbg_req_i),
  .mode_o       (mode_o),
  .ka_req_o     (ka_req_o),
  .poll_o       (poll_o),
  .dbg_grant_o  (dbg_grant_o),
  .holdoff_o    (holdoff_o)
);

// File: tb/usb_dbg_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module usb_dbg_mode_ctrl_tb_top;
  localparam int KHZ  = 1000;
  localparam int KAU  = 40;
  localparam int POLU = 10;
  localparam int KA_N = KHZ * KAU / 1000;   // 40 cycles
  localparam int PL_N = KHZ * POLU / 1000;  // 10 cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic owner_i = 0, dbg_en_i = 0, port_en_i = 0, run_i = 0, susp_i = 0;
  logic port_reset_i = 0, sof_sent_i = 0, dbg_req_i = 0;
  logic [2:0] mode_o;
  logic invalid_o, ka_req_o, poll_o, dbg_grant_o, holdoff_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_dbg_mode_ctrl #(.CLK_KHZ(KHZ), .KA_US(KAU), .POLL_US(POLU)) dut_i (
    .clk(clk), .rst_n(rst_n), .owner_i(owner_i), .dbg_en_i(dbg_en_i),
    .port_en_i(port_en_i), .run_i(run_i), .susp_i(susp_i),
    .port_reset_i(port_reset_i), .sof_sent_i(sof_sent_i), .dbg_req_i(dbg_req_i),
    .mode_o(mode_o), .invalid_o(invalid_o), .ka_req_o(ka_req_o),
    .poll_o(poll_o), .dbg_grant_o(dbg_grant_o), .holdoff_o(holdoff_o)
  );

  // {owner, dbg_en, port_en, run, susp, expected mode[2:0]}
  localparam logic [7:0] VEC [12] = '{
    {5'b00000, 3'd0}, {5'b01111, 3'd0}, {5'b10111, 3'd0}, {5'b11000, 3'd1},
    {5'b11010, 3'd2}, {5'b11001, 3'd1}, {5'b11011, 3'd2}, {5'b11110, 3'd3},
    {5'b11101, 3'd4}, {5'b11111, 3'd4}, {5'b11100, 3'd5}, {5'b00100, 3'd0}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [4:0] c);
    {owner_i, dbg_en_i, port_en_i, run_i, susp_i} = c;
  endtask

  task automatic sof_pulse();
    sof_sent_i = 1;
    step();
    sof_sent_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int polls, kas, grants, badka, badpoll, badgnt, both;
    repeat (4) step();
    rst_n = 1;
    step();
    // Reset state (R1)
    chk(mode_o == 0 && !ka_req_o && !poll_o && !dbg_grant_o && !invalid_o && !holdoff_o,
        "R1 reset state", {mode_o, ka_req_o, poll_o, dbg_grant_o, holdoff_o}, 0);

    // Table walk of the mode decode (R2)
    for (int i = 0; i < 12; i++) begin
      set_ctl(VEC[i][7:3]);
      step();
      chk(mode_o == VEC[i][2:0], "R2 mode decode", mode_o, VEC[i][2:0]);
      chk(invalid_o == (VEC[i][2:0] == 3'd5), "R2 invalid flag", invalid_o,
          VEC[i][2:0] == 3'd5);
    end

    // Clear hold-off left by the suspended vectors (R9)
    set_ctl(5'b00000);
    sof_pulse();
    chk(holdoff_o == 0, "R9 clear by SOF", holdoff_o, 0);

    // Keepalive mode: keepalive and poll timing, grants, coincidence (R3 R4 R5 R10)
    dbg_req_i = 1;
    set_ctl(5'b11000);
    badka = 0; badpoll = 0; badgnt = 0; both = 0; kas = 0; polls = 0;
    for (int n = 1; n <= 2 * KA_N; n++) begin
      step();
      if (ka_req_o != (n % KA_N == 0)) badka++;
      if (poll_o != (n % PL_N == 0)) badpoll++;
      if (dbg_grant_o != (n % PL_N == 0)) badgnt++;
      if (ka_req_o && poll_o) both++;
      kas += ka_req_o;
      polls += poll_o;
    end
    chk(badka == 0 && kas == 2, "R3 keepalive spacing", badka, 0);
    chk(badpoll == 0 && polls == 2 * KA_N / PL_N, "R4 poll spacing", badpoll, 0);
    chk(badgnt == 0, "R5 grant on poll with request", badgnt, 0);
    chk(both == 2, "R10 keepalive and poll together", both, 2);

    // Timer restart on mode change (R7), no keepalive in SOF mode (R3)
    repeat (5) step();
    run_i = 1;
    badpoll = 0; kas = 0;
    for (int n = 1; n <= 25; n++) begin
      step();
      if (poll_o != (n % PL_N == 0)) badpoll++;
      kas += ka_req_o;
    end
    chk(mode_o == 2, "R2 SOF-carried mode", mode_o, 2);
    chk(badpoll == 0, "R7 poll restarts on mode change", badpoll, 0);
    chk(kas == 0, "R3 no keepalive outside mode 1", kas, 0);

    // Port reset hold-off (R8 R9)
    port_reset_i = 1;
    step();
    chk(holdoff_o == 1, "R8 hold-off on port reset", holdoff_o, 1);
    sof_sent_i = 1;
    step();
    sof_sent_i = 0;
    chk(holdoff_o == 1, "R8 SOF during reset ignored", holdoff_o, 1);
    port_reset_i = 0;
    polls = 0; grants = 0;
    for (int n = 0; n < 25; n++) begin
      step();
      polls += poll_o;
      grants += dbg_grant_o;
    end
    chk(polls >= 2 && grants == 0, "R9 no grant while held off", grants, 0);
    chk(holdoff_o == 1, "R9 hold-off sticky without SOF", holdoff_o, 1);
    sof_pulse();
    chk(holdoff_o == 0, "R9 cleared by SOF pulse", holdoff_o, 0);
    grants = 0;
    for (int n = 0; n < PL_N; n++) begin
      step();
      grants += dbg_grant_o;
    end
    chk(grants == 1, "R5 grant resumes after SOF", grants, 1);

    // Suspend then resume (R6 R8 R9)
    set_ctl(5'b11111);
    step();
    chk(mode_o == 4 && holdoff_o == 1, "R8 suspend sets hold-off", {mode_o, holdoff_o}, 9);
    polls = 0; grants = 0;
    for (int n = 0; n < 25; n++) begin
      step();
      polls += poll_o;
      grants += dbg_grant_o;
    end
    chk(polls == 0 && grants == 0, "R6 quiet while suspended", polls + grants, 0);
    susp_i = 0;
    polls = 0; grants = 0;
    for (int n = 1; n <= 25; n++) begin
      step();
      polls += poll_o;
      grants += dbg_grant_o;
    end
    chk(mode_o == 3, "R2 shared mode after resume", mode_o, 3);
    chk(polls == 2 && grants == 0, "R9 polls but no grant before SOF", grants, 0);
    sof_pulse();
    chk(holdoff_o == 0, "R9 SOF after resume clears", holdoff_o, 0);

    // Invalid combination (R2 R6)
    run_i = 0;
    step();
    chk(invalid_o == 1 && mode_o == 5, "R2 invalid combination", mode_o, 5);
    polls = 0;
    for (int n = 0; n < 25; n++) begin
      step();
      polls += poll_o + dbg_grant_o;
    end
    chk(polls == 0, "R6 quiet when invalid", polls, 0);

    // Not in use (R1)
    set_ctl(5'b01000);
    step();
    polls = 0;
    for (int n = 0; n < KA_N + 5; n++) begin
      step();
      polls += poll_o + ka_req_o + dbg_grant_o + invalid_o;
    end
    chk(mode_o == 0 && polls == 0, "R1 unused port quiet", polls, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule